// File: doc/BRIEF.md
# I2C Master Interrupt and Abort Status Unit

This unit gathers the event and error conditions of an I2C master controller and presents them to software through a small read port. Single-cycle pulses from the byte engine and the FIFOs set sticky status bits. Two FIFO conditions, transmit empty and receive full, are live comparisons of a FIFO level against its threshold. A raw status word shows every condition. A masked word, which is the raw word ANDed with a software mask, drives a single interrupt line.

When the engine aborts a transmission, it pulses an abort strobe together with a cause vector. The unit records every cause in an abort source word. While the abort remains pending, the unit holds the transmit FIFO in reset. Software clears conditions by reading clear selectors. There is one selector per sticky condition and one that clears everything. Clearing the abort bit also empties the source word and releases the FIFO hold.

Top module: `i2c_irq_status`

## Requirements
- R1: Raw status bit positions: [0] RX underflow, [1] RX overflow, [2] RX full, [3] TX overflow, [4] TX empty, [5] TX abort, [6] start seen, [7] stop seen. A pulse on an event input sets its bit from the following cycle, and the bit stays set until it is cleared.
- R2: TX empty reads 1 whenever tx_level <= tx_thresh. RX full reads 1 whenever rx_level > rx_thresh. Both follow their inputs in the same cycle and are never latched.
- R3: A read strobe (rd_en high) with rd_sel 4, 5, 6, 7, 8 or 9 clears, respectively, RX underflow, RX overflow, TX overflow, TX abort, start seen or stop seen, from the next cycle. No other bit changes. During that read, rd_data returns the bit's value before the clear, zero-extended.
- R4: rd_sel 3 with a read strobe clears every sticky bit, including start seen, stop seen, TX abort and the abort source word. During that read, rd_data returns the raw word restricted to the sticky bits.
- R5: Abort source bits: [0] user abort request, [1] arbitration lost, [2] address NACK in 7-bit mode, [3] NACK on the first 10-bit address byte, [4] NACK on the second 10-bit address byte, [5] data NACK, [6] general-call NACK, [7] general-call read attempt, [8] restart while restarts are disabled, [9] acknowledged start byte. An abort pulse sets TX abort and ORs abort_cause into the word. rd_sel 2 reads the word.
- R6: The abort source word clears in the same cycle as the TX abort bit.
- R7: tx_hold rises in the cycle after an abort pulse. It falls in the cycle after the TX abort bit is cleared.
- R8: rd_sel 1 returns raw AND int_mask. irq is high exactly when that word is nonzero.
- R9: When an event pulse and the clear of its bit occur in the same cycle, the bit ends up set.
- R10: Reading rd_sel 0, 1 or 2 changes no state.
- R11: After reset, every sticky bit and the source word are 0, and tx_hold and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_under | input | 1 | RX underflow pulse |
| ev_rx_over | input | 1 | RX overflow pulse |
| ev_tx_over | input | 1 | TX overflow pulse |
| ev_start | input | 1 | Start condition seen pulse |
| ev_stop | input | 1 | Stop condition seen pulse |
| ev_abort | input | 1 | Transmit abort pulse |
| abort_cause | input | 10 | Cause bits sampled with ev_abort |
| tx_level | input | LVL_W | TX FIFO fill level |
| tx_thresh | input | LVL_W | TX empty threshold |
| rx_level | input | LVL_W | RX FIFO fill level |
| rx_thresh | input | LVL_W | RX full threshold |
| int_mask | input | 8 | Interrupt enable mask |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 4 | Read selector |
| rd_data | output | DATA_W | Selected word (combinational) |
| irq | output | 1 | Interrupt request |
| tx_hold | output | 1 | Holds the TX FIFO in reset |

## Verification
Sticky bits, the source word and tx_hold change one clock edge after the pulse or clear read that causes them. The level bits, rd_data and irq respond combinationally in the same cycle. The bench therefore drives each vector at a falling edge and samples rd_data shortly afterwards. This captures the value returned by a read before its clear takes effect. At the next falling edge, after exactly one rising edge, the bench walks rd_sel through the raw and source selectors to observe the updated state with the vector's levels and mask still applied.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int ST_W   = 8;
  localparam int ABRT_W = 10;
  localparam int EV_W   = 5;

  localparam int ST_RXU = 0;
  localparam int ST_RXO = 1;
  localparam int ST_RXF = 2;
  localparam int ST_TXO = 3;
  localparam int ST_TXE = 4;
  localparam int ST_ABT = 5;
  localparam int ST_STA = 6;
  localparam int ST_STP = 7;

  // sticky event bank order
  localparam int EV_RXU = 0;
  localparam int EV_RXO = 1;
  localparam int EV_TXO = 2;
  localparam int EV_STA = 3;
  localparam int EV_STP = 4;

  localparam logic [ST_W-1:0] STICKY_MASK = 8'hEB;

  typedef enum logic [3:0] {
    SEL_RAW     = 4'd0,
    SEL_MASKED  = 4'd1,
    SEL_SRC     = 4'd2,
    SEL_CLR_ALL = 4'd3,
    SEL_CLR_RXU = 4'd4,
    SEL_CLR_RXO = 4'd5,
    SEL_CLR_TXO = 4'd6,
    SEL_CLR_ABT = 4'd7,
    SEL_CLR_STA = 4'd8,
    SEL_CLR_STP = 4'd9
  } rd_sel_e;

  function automatic logic lvl_at_or_below(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl <= thr;
  endfunction

  function automatic logic lvl_above(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl > thr;
  endfunction

  function automatic logic [ST_W-1:0] assemble_raw(input logic [EV_W-1:0] ev,
                                                   input logic abt, input logic txe,
                                                   input logic rxf);
    logic [ST_W-1:0] r;
    r         = '0;
    r[ST_RXU] = ev[EV_RXU];
    r[ST_RXO] = ev[EV_RXO];
    r[ST_RXF] = rxf;
    r[ST_TXO] = ev[EV_TXO];
    r[ST_TXE] = txe;
    r[ST_ABT] = abt;
    r[ST_STA] = ev[EV_STA];
    r[ST_STP] = ev[EV_STP];
    return r;
  endfunction
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= (q & ~clr_i[i]) | set_i[i];
    end
    assign q_o[i] = q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_i,
  input  logic [W-1:0] cause_i,
  input  logic         clr_i,
  output logic         pending_o,
  output logic [W-1:0] src_o,
  output logic         hold_o
);
  logic         pend_q;
  logic [W-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      src_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | abort_i;
      if (abort_i) src_q <= (clr_i ? '0 : src_q) | cause_i;
      else if (clr_i) src_q <= '0;
    end
  end

  assign pending_o = pend_q;
  assign src_o     = src_q;
  assign hold_o    = pend_q;

  // R5
  cause_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> ((src_o & $past(cause_i)) == $past(cause_i)));
  // R6
  src_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !abort_i) |=> (src_o == '0));
  // R7
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(abort_i));
  // R7
  hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> $past(clr_i));
endmodule

// File: rtl/irq_read_decode.sv
module irq_read_decode
  import i2c_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [3:0]      rd_sel,
  output logic [EV_W-1:0] clr_ev,
  output logic            clr_abt
);
  always_comb begin
    clr_ev  = '0;
    clr_abt = 1'b0;
    if (rd_en) begin
      case (rd_sel)
        SEL_CLR_ALL: begin clr_ev = '1; clr_abt = 1'b1; end
        SEL_CLR_RXU: clr_ev[EV_RXU] = 1'b1;
        SEL_CLR_RXO: clr_ev[EV_RXO] = 1'b1;
        SEL_CLR_TXO: clr_ev[EV_TXO] = 1'b1;
        SEL_CLR_ABT: clr_abt = 1'b1;
        SEL_CLR_STA: clr_ev[EV_STA] = 1'b1;
        SEL_CLR_STP: clr_ev[EV_STP] = 1'b1;
        default: ;
      endcase
    end
  end

  // R3
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel != SEL_CLR_ALL) |-> $onehot0({clr_ev, clr_abt}));
  // R10
  plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_RAW || rd_sel == SEL_MASKED || rd_sel == SEL_SRC) |-> ({clr_ev, clr_abt} == '0));
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_under,
  input  logic              ev_rx_over,
  input  logic              ev_tx_over,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_abort,
  input  logic [9:0]        abort_cause,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  tx_thresh,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rx_thresh,
  input  logic [7:0]        int_mask,
  input  logic              rd_en,
  input  logic [3:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              tx_hold
);
  logic [EV_W-1:0]   ev_set, ev_q, clr_ev;
  logic              clr_abt, abt_pend;
  logic [ABRT_W-1:0] abt_src;
  logic              lvl_txe, lvl_rxf;
  logic [ST_W-1:0]   raw_status, masked_status;

  assign ev_set[EV_RXU] = ev_rx_under;
  assign ev_set[EV_RXO] = ev_rx_over;
  assign ev_set[EV_TXO] = ev_tx_over;
  assign ev_set[EV_STA] = ev_start;
  assign ev_set[EV_STP] = ev_stop;

  irq_read_decode u_dec (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .clr_ev(clr_ev), .clr_abt(clr_abt)
  );

  irq_event_bank #(.N(EV_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(clr_ev), .q_o(ev_q)
  );

  irq_abort_capture #(.W(ABRT_W)) u_abt (
    .clk(clk), .rst_n(rst_n), .abort_i(ev_abort), .cause_i(abort_cause),
    .clr_i(clr_abt), .pending_o(abt_pend), .src_o(abt_src), .hold_o(tx_hold)
  );

  assign lvl_txe       = lvl_at_or_below(16'(tx_level), 16'(tx_thresh));
  assign lvl_rxf       = lvl_above(16'(rx_level), 16'(rx_thresh));
  assign raw_status    = assemble_raw(ev_q, abt_pend, lvl_txe, lvl_rxf);
  assign masked_status = raw_status & int_mask;
  assign irq           = |masked_status;

  always_comb begin
    case (rd_sel)
      SEL_RAW:     rd_data = DATA_W'(raw_status);
      SEL_MASKED:  rd_data = DATA_W'(masked_status);
      SEL_SRC:     rd_data = DATA_W'(abt_src);
      SEL_CLR_ALL: rd_data = DATA_W'(raw_status & STICKY_MASK);
      SEL_CLR_RXU: rd_data = DATA_W'(raw_status[ST_RXU]);
      SEL_CLR_RXO: rd_data = DATA_W'(raw_status[ST_RXO]);
      SEL_CLR_TXO: rd_data = DATA_W'(raw_status[ST_TXO]);
      SEL_CLR_ABT: rd_data = DATA_W'(raw_status[ST_ABT]);
      SEL_CLR_STA: rd_data = DATA_W'(raw_status[ST_STA]);
      SEL_CLR_STP: rd_data = DATA_W'(raw_status[ST_STP]);
      default:     rd_data = '0;
    endcase
  end

  // R1
  start_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> raw_status[ST_STA]);
  // R2
  txe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> raw_status[ST_TXE]);
  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_CLR_ALL && !ev_abort && ev_set == '0)
      |=> ((raw_status & STICKY_MASK) == '0 && abt_src == '0));
  // R10
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_RAW && !ev_abort && ev_set == '0)
      |=> $stable(raw_status & STICKY_MASK));
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!tx_hold && abt_src == '0));
endmodule

// File: tb/tb_i2c_irq_status.sv
module tb_i2c_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [4:0]  ev;      // [0]rxu [1]rxo [2]txo [3]start [4]stop
    logic        ab;
    logic [9:0]  cause;
    logic [5:0]  txl, txt, rxl, rxt;
    logic [7:0]  mask;
    logic        rd;
    logic [3:0]  sel;
    logic [15:0] exp_rd;
    logic [7:0]  exp_raw;
    logic [9:0]  exp_src;
    logic        exp_irq;
    logic        exp_hold;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'b01000,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h00,1'b0,4'd0,16'h0000,8'h40,10'h000,1'b0,1'b0}, // R1
    '{5'b00001,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h01,1'b0,4'd0,16'h0000,8'h41,10'h000,1'b1,1'b0}, // R8
    '{5'b00000,1'b1,10'h004,6'd5,6'd2,6'd0,6'd3,8'h00,1'b0,4'd0,16'h0000,8'h61,10'h004,1'b0,1'b1}, // R5
    '{5'b00000,1'b1,10'h020,6'd5,6'd2,6'd0,6'd3,8'h20,1'b1,4'd2,16'h0004,8'h61,10'h024,1'b1,1'b1}, // R5
    '{5'b00000,1'b0,10'h000,6'd1,6'd2,6'd4,6'd3,8'h14,1'b0,4'd0,16'h0000,8'h75,10'h024,1'b1,1'b1}, // R2
    '{5'b00000,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h01,1'b1,4'd4,16'h0001,8'h60,10'h024,1'b0,1'b1}, // R3
    '{5'b00000,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h20,1'b1,4'd7,16'h0001,8'h40,10'h000,1'b0,1'b0}, // R6
    '{5'b01000,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h40,1'b1,4'd8,16'h0001,8'h40,10'h000,1'b1,1'b0}, // R9
    '{5'b10110,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h00,1'b0,4'd0,16'h0000,8'hCA,10'h000,1'b0,1'b0}, // R1
    '{5'b00000,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h00,1'b1,4'd0,16'h00CA,8'hCA,10'h000,1'b0,1'b0}, // R10
    '{5'b00000,1'b1,10'h200,6'd5,6'd2,6'd0,6'd3,8'h20,1'b0,4'd0,16'h0000,8'hEA,10'h200,1'b1,1'b1}, // R7
    '{5'b00000,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'hFF,1'b1,4'd3,16'h00EA,8'h00,10'h000,1'b0,1'b0}, // R4
    '{5'b00000,1'b0,10'h000,6'd0,6'd2,6'd0,6'd3,8'hFF,1'b1,4'd1,16'h0010,8'h10,10'h000,1'b1,1'b0}, // R8
    '{5'b00000,1'b0,10'h000,6'd5,6'd2,6'd0,6'd3,8'h00,1'b1,4'd6,16'h0000,8'h00,10'h000,1'b0,1'b0}  // R3
  };
  localparam string TAGS [NV] = '{"R1","R8","R5","R5","R2","R3","R6","R9","R1","R10","R7","R4","R8","R3"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_rx_under, ev_rx_over, ev_tx_over, ev_start, ev_stop, ev_abort;
  logic [9:0]  abort_cause;
  logic [5:0]  tx_level, tx_thresh, rx_level, rx_thresh;
  logic [7:0]  int_mask;
  logic        rd_en;
  logic [3:0]  rd_sel;
  logic [15:0] rd_data;
  logic        irq, tx_hold;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_status dut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_under(ev_rx_under), .ev_rx_over(ev_rx_over), .ev_tx_over(ev_tx_over),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_abort(ev_abort),
    .abort_cause(abort_cause), .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rx_level(rx_level), .rx_thresh(rx_thresh), .int_mask(int_mask),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .tx_hold(tx_hold)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_pulses();
    {ev_rx_under, ev_rx_over, ev_tx_over, ev_start, ev_stop, ev_abort} = '0;
    abort_cause = '0;
    rd_en = 1'b0;
  endtask

  initial begin
    idle_pulses();
    rd_sel = 4'd0; int_mask = 8'hFF;
    tx_level = 6'd5; tx_thresh = 6'd2; rx_level = 6'd0; rx_thresh = 6'd3;
    repeat (3) @(negedge clk);
    // R11: reset state seen at ports while held and after release
    #1 check("R11", "raw in reset", rd_data, 16'h0000);
    check("R11", "irq in reset", {15'b0, irq}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "hold after reset", {15'b0, tx_hold}, 16'h0000);
    rd_sel = 4'd2; #1
    check("R11", "source after reset", rd_data, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ev_stop, ev_start, ev_tx_over, ev_rx_over, ev_rx_under} = VECS[i].ev;
      ev_abort = VECS[i].ab; abort_cause = VECS[i].cause;
      tx_level = VECS[i].txl; tx_thresh = VECS[i].txt;
      rx_level = VECS[i].rxl; rx_thresh = VECS[i].rxt;
      int_mask = VECS[i].mask; rd_en = VECS[i].rd; rd_sel = VECS[i].sel;
      #1;
      if (VECS[i].rd) check(TAGS[i], $sformatf("vec %0d read data", i), rd_data, VECS[i].exp_rd);
      @(negedge clk);
      idle_pulses();
      rd_sel = 4'd0; #1
      check(TAGS[i], $sformatf("vec %0d raw", i), rd_data, 16'(VECS[i].exp_raw));
      rd_sel = 4'd2; #1
      check(TAGS[i], $sformatf("vec %0d source", i), rd_data, 16'(VECS[i].exp_src));
      check(TAGS[i], $sformatf("vec %0d irq", i), {15'b0, irq}, {15'b0, VECS[i].exp_irq});
      check("R7", $sformatf("vec %0d hold", i), {15'b0, tx_hold}, {15'b0, VECS[i].exp_hold});
    end

    // R2 boundary: equal levels -> TX empty set, RX full clear
    tx_level = 6'd3; tx_thresh = 6'd3; rx_level = 6'd3; rx_thresh = 6'd3;
    rd_sel = 4'd0; #1
    check("R2", "levels equal", rd_data, 16'h0010);
    rx_level = 6'd4; tx_level = 6'd4; #1
    check("R2", "levels one above", rd_data, 16'h0004);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule